// File: doc/BRIEF.md
# Integer Execute Unit (64-bit base integer set)

This block is the combinational integer datapath of a 64-bit load/store pipeline. The decode stage hands it two register operands, an immediate that is already sign-extended, the program counter, an operand-select bit and a 5-bit operation code. Within the same cycle it returns a result word and a branch-taken flag.

It covers:

- full-width add, subtract, shifts, set-less-than and bitwise logic, in register and immediate forms;
- the 32-bit "word" add and shifts, whose results are sign-extended to the full width;
- the upper-immediate results and the jump link value;
- the six conditional branch comparisons.

The enclosing stage registers the outputs. Fetch, decode, register file, memory and traps are handled elsewhere.

Top module: `ixu_exec`

## Requirements
- R1: Operation codes on `op` are: ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8, AND=9, ADDW=10, SLLW=11, SRLW=12, SRAW=13, LUI=14, AUIPC=15, JAL=16, BEQ=17, BNE=18, BLT=19, BGE=20, BLTU=21, BGEU=22. For codes 0 to 13 the second operand is `imm_val` when `sel_imm`=1 and `src_b` when `sel_imm`=0; the immediate is used exactly as given, already sign-extended.
- R2: ADD returns `src_a` plus the second operand and SUB returns `src_a` minus it, both modulo 2^XLEN.
- R3: Every output settles combinationally from the current inputs, and all-zero inputs give `result`=0 and `br_taken`=0.
- R4: SLL, SRL and SRA shift `src_a` by the low log2(XLEN) bits of the second operand (6 bits when XLEN=64). SRA fills vacated bits with bit XLEN-1 of `src_a`, and SRL fills them with zeros.
- R5: SLT (signed) and SLTU (unsigned) return 1 when `src_a` is less than the second operand and 0 otherwise. All upper bits are zero.
- R6: AND, OR and XOR return the bitwise combination of `src_a` and the second operand.
- R7: ADDW adds the low 32 bits of both operands, ignores all higher input bits, and sign-extends bit 31 of the 32-bit sum to the full width.
- R8: SLLW, SRLW and SRAW shift the low 32 bits of `src_a` by the low 5 bits of the second operand. SRAW takes its fill from bit 31 of `src_a`. The 32-bit result is sign-extended from bit 31.
- R9: LUI returns `imm_val`. AUIPC returns `pc` + `imm_val`.
- R10: JAL returns `pc` + 4 as the link value.
- R11: Branch codes always compare `src_a` with `src_b`, whatever `sel_imm` is. `br_taken` is 1 exactly when the condition holds:
  - BEQ: equal;
  - BNE: not equal;
  - BLT: signed less than;
  - BGE: signed greater or equal;
  - BLTU: unsigned less than;
  - BGEU: unsigned greater or equal.
  The result is 0 for all branch codes.
- R12: `br_taken` is 0 for every non-branch code. Codes 23 to 31 return `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | XLEN | First register operand |
| src_b | input | XLEN | Second register operand |
| imm_val | input | XLEN | Sign-extended immediate |
| pc | input | XLEN | Program counter of the instruction |
| sel_imm | input | 1 | 1 selects `imm_val` as the second ALU operand |
| op | input | 5 | Operation code (see R1) |
| result | output | XLEN | Result word |
| br_taken | output | 1 | Branch condition holds |

## Verification
The bench builds the unit with XLEN=64, which turns on the word datapath. Shift amounts therefore use 6 and 5 bits, and so reach the cases where bit 5 of the amount is set or is masked away. At this width the word checks can place bit 63 and bit 31 of the operand at different values, which separates a SRAW fill taken from bit 31 from one taken from bit 63. It also shows whether ADDW ignores the upper half of its inputs. Operand patterns mix the sign-boundary values (zero, all ones, the most negative and the most positive) with random words, so that the signed and unsigned comparisons disagree on many vectors.

// File: rtl/ixu_pkg.sv
package ixu_pkg;

   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,
      OP_SUB   = 5'd1,
      OP_SLL   = 5'd2,
      OP_SLT   = 5'd3,
      OP_SLTU  = 5'd4,
      OP_XOR   = 5'd5,
      OP_SRL   = 5'd6,
      OP_SRA   = 5'd7,
      OP_OR    = 5'd8,
      OP_AND   = 5'd9,
      OP_ADDW  = 5'd10,
      OP_SLLW  = 5'd11,
      OP_SRLW  = 5'd12,
      OP_SRAW  = 5'd13,
      OP_LUI   = 5'd14,
      OP_AUIPC = 5'd15,
      OP_JAL   = 5'd16,
      OP_BEQ   = 5'd17,
      OP_BNE   = 5'd18,
      OP_BLT   = 5'd19,
      OP_BGE   = 5'd20,
      OP_BLTU  = 5'd21,
      OP_BGEU  = 5'd22
   } ixu_op_e;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned LINK_STEP = 4;

   function automatic logic is_branch(input logic [4:0] code);
      return (code >= 5'(OP_BEQ)) && (code <= 5'(OP_BGEU));
   endfunction

   function automatic logic is_word_op(input logic [4:0] code);
      return (code >= 5'(OP_ADDW)) && (code <= 5'(OP_SRAW));
   endfunction

endpackage

// File: rtl/ixu_addsub.sv
module ixu_addsub #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   input  logic         minus,
   output logic [W-1:0] total
);

   initial begin
      if (W < 1) $error("ixu_addsub: width must be positive");
   end

   logic [W-1:0] rhs_eff;

   assign rhs_eff = minus ? ~rhs : rhs;
   assign total   = lhs + rhs_eff + {{(W-1){1'b0}}, minus};

endmodule

// File: rtl/ixu_shift.sv
module ixu_shift #(
   parameter  int unsigned W  = 64,
   localparam int unsigned SW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] amt,
   input  logic          go_right,
   input  logic          arith,
   output logic [W-1:0]  dout
);

   initial begin
      if (W < 2 || (1 << SW) != W) $error("ixu_shift: width must be a power of two");
   end

   logic [W-1:0] din_rev;
   logic [W-1:0] out_rev;
   logic [W-1:0] stage [SW+1];
   logic         fill;

   // Bit reversal lets a single right-shift network serve left shifts too.
   for (genvar i = 0; i < W; i++) begin : g_rev
      assign din_rev[i] = din[W-1-i];
      assign out_rev[i] = stage[SW][W-1-i];
   end

   assign fill     = arith & go_right & din[W-1];
   assign stage[0] = go_right ? din : din_rev;

   for (genvar s = 0; s < SW; s++) begin : g_stage
      localparam int unsigned D = 1 << s;
      assign stage[s+1] = amt[s] ? {{D{fill}}, stage[s][W-1:D]} : stage[s];
   end

   assign dout = go_right ? stage[SW] : out_rev;

endmodule

// File: rtl/ixu_cmp.sv
module ixu_cmp #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   output logic         same,
   output logic         below_u,
   output logic         below_s
);

   logic [W:0] diff;

   assign diff    = {1'b0, lhs} - {1'b0, rhs};
   assign same    = (lhs == rhs);
   assign below_u = diff[W];
   assign below_s = (lhs[W-1] ^ rhs[W-1]) ? lhs[W-1] : below_u;

endmodule

// File: rtl/ixu_exec.sv
module ixu_exec
   import ixu_pkg::*;
#(
   parameter  int unsigned XLEN     = 64,
   localparam int unsigned SHW      = $clog2(XLEN),
   localparam bit          HAS_WORD = (XLEN > WORD_W)
) (
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   input  logic [XLEN-1:0] imm_val,
   input  logic [XLEN-1:0] pc,
   input  logic            sel_imm,
   input  logic [4:0]      op,
   output logic [XLEN-1:0] result,
   output logic            br_taken
);

   initial begin
      if (XLEN != 32 && XLEN != 64) $error("ixu_exec: XLEN must be 32 or 64");
   end

   ixu_op_e         opc;
   logic [XLEN-1:0] opb;
   logic [XLEN-1:0] sum_main;
   logic [XLEN-1:0] sum_pc;
   logic [XLEN-1:0] pc_off;
   logic [XLEN-1:0] shf_main;
   logic [XLEN-1:0] word_res;
   logic            alu_eq, alu_ltu, alu_lts;
   logic            br_eq, br_ltu, br_lts;
   logic            main_right, main_arith;

   assign opc = ixu_op_e'(op);
   assign opb = sel_imm ? imm_val : src_b;

   // Full-width add/subtract.
   ixu_addsub #(.W(XLEN)) u_add_main (
      .lhs   (src_a),
      .rhs   (opb),
      .minus (opc == OP_SUB),
      .total (sum_main)
   );

   // Program-counter adder shared by AUIPC and the jump link.
   assign pc_off = (opc == OP_JAL) ? XLEN'(LINK_STEP) : imm_val;

   ixu_addsub #(.W(XLEN)) u_add_pc (
      .lhs   (pc),
      .rhs   (pc_off),
      .minus (1'b0),
      .total (sum_pc)
   );

   // Full-width shifter.
   assign main_right = (opc == OP_SRL) || (opc == OP_SRA);
   assign main_arith = (opc == OP_SRA);

   ixu_shift #(.W(XLEN)) u_shf_main (
      .din      (src_a),
      .amt      (opb[SHW-1:0]),
      .go_right (main_right),
      .arith    (main_arith),
      .dout     (shf_main)
   );

   // Set-less-than comparator on the selected operand.
   ixu_cmp #(.W(XLEN)) u_cmp_alu (
      .lhs     (src_a),
      .rhs     (opb),
      .same    (alu_eq),
      .below_u (alu_ltu),
      .below_s (alu_lts)
   );

   // Branch comparator always uses the register operand.
   ixu_cmp #(.W(XLEN)) u_cmp_br (
      .lhs     (src_a),
      .rhs     (src_b),
      .same    (br_eq),
      .below_u (br_ltu),
      .below_s (br_lts)
   );

   // Word datapath, only present when the machine is wider than a word.
   if (HAS_WORD) begin : g_word
      logic [WORD_W-1:0] w_sum;
      logic [WORD_W-1:0] w_shf;
      logic [WORD_W-1:0] w_pick;
      logic              w_right, w_arith;

      ixu_addsub #(.W(WORD_W)) u_add_w (
         .lhs   (src_a[WORD_W-1:0]),
         .rhs   (opb[WORD_W-1:0]),
         .minus (1'b0),
         .total (w_sum)
      );

      assign w_right = (opc == OP_SRLW) || (opc == OP_SRAW);
      assign w_arith = (opc == OP_SRAW);

      ixu_shift #(.W(WORD_W)) u_shf_w (
         .din      (src_a[WORD_W-1:0]),
         .amt      (opb[$clog2(WORD_W)-1:0]),
         .go_right (w_right),
         .arith    (w_arith),
         .dout     (w_shf)
      );

      assign w_pick   = (opc == OP_ADDW) ? w_sum : w_shf;
      assign word_res = {{(XLEN-WORD_W){w_pick[WORD_W-1]}}, w_pick};
   end else begin : g_noword
      assign word_res = '0;
   end

   always_comb begin
      result   = '0;
      br_taken = 1'b0;
      case (opc)
         OP_ADD, OP_SUB:   result = sum_main;
         OP_SLL, OP_SRL,
         OP_SRA:           result = shf_main;
         OP_SLT:           result = {{(XLEN-1){1'b0}}, alu_lts};
         OP_SLTU:          result = {{(XLEN-1){1'b0}}, alu_ltu};
         OP_XOR:           result = src_a ^ opb;
         OP_OR:            result = src_a | opb;
         OP_AND:           result = src_a & opb;
         OP_ADDW, OP_SLLW,
         OP_SRLW, OP_SRAW: result = word_res;
         OP_LUI:           result = imm_val;
         OP_AUIPC, OP_JAL: result = sum_pc;
         OP_BEQ:           br_taken = br_eq;
         OP_BNE:           br_taken = ~br_eq;
         OP_BLT:           br_taken = br_lts;
         OP_BGE:           br_taken = ~br_lts;
         OP_BLTU:          br_taken = br_ltu;
         OP_BGEU:          br_taken = ~br_ltu;
         default: begin
            result   = '0;
            br_taken = 1'b0;
         end
      endcase
   end

   logic unused_alu_eq;
   assign unused_alu_eq = alu_eq;

endmodule

// File: rtl/ixu_exec_chk.sv
module ixu_exec_chk
   import ixu_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input logic [XLEN-1:0] src_a,
   input logic [XLEN-1:0] src_b,
   input logic [XLEN-1:0] imm_val,
   input logic [XLEN-1:0] pc,
   input logic            sel_imm,
   input logic [4:0]      op,
   input logic [XLEN-1:0] result,
   input logic            br_taken
);

   always_comb begin
      // R12
      taken_idle_chk: assert (is_branch(op) || !br_taken)
         else $error("br_taken high for non-branch op %0d", op);
      // R11
      beq_match_chk: assert (!(op == 5'(OP_BEQ) && br_taken) || (src_a == src_b))
         else $error("BEQ taken with unequal operands");
      // R11
      bne_match_chk: assert (!(op == 5'(OP_BNE) && br_taken) || (src_a != src_b))
         else $error("BNE taken with equal operands");
      // R11
      branch_res_zero_chk: assert (!is_branch(op) || (result == '0))
         else $error("branch op produced nonzero result");
      // R5
      slt_bool_chk: assert (!(op == 5'(OP_SLT) || op == 5'(OP_SLTU)) || (result[XLEN-1:1] == '0))
         else $error("set-less-than result not boolean");
      // R9
      lui_pass_chk: assert (op != 5'(OP_LUI) || result == imm_val)
         else $error("LUI result differs from immediate");
   end

   if (XLEN > WORD_W) begin : g_wchk
      always_comb begin
         // R7
         word_sext_chk: assert (!is_word_op(op) ||
                                (result[XLEN-1:WORD_W] == {(XLEN-WORD_W){result[WORD_W-1]}}))
            else $error("word result not sign-extended");
      end
   end

   logic [XLEN:0] unused_in;
   assign unused_in = {pc ^ imm_val ^ src_b, sel_imm};

endmodule

bind ixu_exec ixu_exec_chk #(.XLEN(XLEN)) u_chk (
   .src_a    (src_a),
   .src_b    (src_b),
   .imm_val  (imm_val),
   .pc       (pc),
   .sel_imm  (sel_imm),
   .op       (op),
   .result   (result),
   .br_taken (br_taken)
);

// File: tb/ixu_exec_test.sv
module ixu_exec_test;

   localparam int unsigned XLEN = 64;
   localparam int NV = 31;
   localparam int NRAND = 3000;
   localparam int WATCHDOG_CYC = 150000;

   typedef struct packed {
      logic [4:0]  op;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] imm;
      logic [63:0] pcv;
      logic        sel;
      logic [63:0] exp;
      logic        tk;
      logic [7:0]  req;
   } vec_t;

   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] MSB  = 64'h8000_0000_0000_0000;

   localparam vec_t TBL [NV] = '{
      '{5'd0,  64'd5, 64'd7, 64'd0, 64'd0, 1'b0, 64'd12, 1'b0, 8'd2},                 // R2 add
      '{5'd1,  64'd3, 64'd5, 64'd0, 64'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 8'd2}, // R2 sub wraps
      '{5'd0,  64'd0, 64'd123, ONES, 64'd0, 1'b1, ONES, 1'b0, 8'd1},                   // R1 immediate selected
      '{5'd2,  64'd1, 64'd63, 64'd0, 64'd0, 1'b0, MSB, 1'b0, 8'd4},                    // R4 sll by 63
      '{5'd2,  64'd1, 64'h41, 64'd0, 64'd0, 1'b0, 64'd2, 1'b0, 8'd4},                  // R4 amount masked
      '{5'd7,  MSB, 64'd4, 64'd0, 64'd0, 1'b0, 64'hF800_0000_0000_0000, 1'b0, 8'd4},   // R4 sra fill
      '{5'd6,  MSB, 64'd4, 64'd0, 64'd0, 1'b0, 64'h0800_0000_0000_0000, 1'b0, 8'd4},   // R4 srl zero fill
      '{5'd3,  ONES, 64'd1, 64'd0, 64'd0, 1'b0, 64'd1, 1'b0, 8'd5},                    // R5 signed
      '{5'd4,  ONES, 64'd1, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 8'd5},                    // R5 unsigned
      '{5'd3,  64'hFFFF_FFFF_FFFF_FFFB, 64'd0, 64'hFFFF_FFFF_FFFF_FFFD, 64'd0, 1'b1, 64'd1, 1'b0, 8'd5}, // R5 imm
      '{5'd5,  64'hFF00, 64'd0, 64'h0FF0, 64'd0, 1'b1, 64'hF0F0, 1'b0, 8'd6},          // R6 xor imm
      '{5'd9,  64'hF0F0, 64'hFF00, 64'd0, 64'd0, 1'b0, 64'hF000, 1'b0, 8'd6},          // R6 and
      '{5'd8,  64'hF0F0, 64'hFF00, 64'd0, 64'd0, 1'b0, 64'hFFF0, 1'b0, 8'd6},          // R6 or
      '{5'd10, 64'h7FFF_FFFF, 64'd0, 64'd1, 64'd0, 1'b1, 64'hFFFF_FFFF_8000_0000, 1'b0, 8'd7}, // R7 overflow
      '{5'd10, 64'hFFFF_FFFF_0000_0005, 64'd3, 64'd0, 64'd0, 1'b0, 64'd8, 1'b0, 8'd7}, // R7 upper ignored
      '{5'd13, MSB, 64'd4, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 8'd8},                     // R8 fill from bit 31
      '{5'd13, 64'h8000_0000, 64'd4, 64'd0, 64'd0, 1'b0, 64'hFFFF_FFFF_F800_0000, 1'b0, 8'd8}, // R8
      '{5'd11, 64'd1, 64'h3F, 64'd0, 64'd0, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0, 8'd8}, // R8 5-bit amount
      '{5'd12, 64'hFFFF_FFFF_8000_0000, 64'h1F, 64'd0, 64'd0, 1'b0, 64'd1, 1'b0, 8'd8}, // R8 srlw
      '{5'd14, 64'h1234, 64'd0, 64'hFFFF_FFFF_ABCD_E000, 64'd0, 1'b0, 64'hFFFF_FFFF_ABCD_E000, 1'b0, 8'd9}, // R9
      '{5'd15, 64'd0, 64'd0, 64'h2000, 64'h1000, 1'b0, 64'h3000, 1'b0, 8'd9},          // R9 auipc
      '{5'd16, 64'd0, 64'd0, 64'd0, 64'h1000, 1'b0, 64'h1004, 1'b0, 8'd10},            // R10 link
      '{5'd17, 64'd5, 64'd5, 64'd0, 64'd0, 1'b0, 64'd0, 1'b1, 8'd11},                  // R11 beq
      '{5'd18, 64'd5, 64'd5, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 8'd11},                  // R11 bne
      '{5'd19, ONES, 64'd0, 64'd0, 64'd0, 1'b0, 64'd0, 1'b1, 8'd11},                   // R11 blt
      '{5'd20, ONES, 64'd0, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 8'd11},                   // R11 bge
      '{5'd21, ONES, 64'd0, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 8'd11},                   // R11 bltu
      '{5'd22, ONES, 64'd0, 64'd0, 64'd0, 1'b0, 64'd0, 1'b1, 8'd11},                   // R11 bgeu
      '{5'd17, 64'd5, 64'd5, 64'd9, 64'd0, 1'b1, 64'd0, 1'b1, 8'd11},                  // R11 ignores sel_imm
      '{5'd31, ONES, ONES, ONES, ONES, 1'b1, 64'd0, 1'b0, 8'd12},                      // R12 unused code
      '{5'd9,  64'd5, 64'd5, 64'd0, 64'd0, 1'b0, 64'd5, 1'b0, 8'd12}                   // R12 no taken
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [63:0] src_a = '0, src_b = '0, imm_val = '0, pc = '0;
   logic        sel_imm = 1'b0;
   logic [4:0]  op = '0;
   logic [63:0] result;
   logic        br_taken;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   ixu_exec #(.XLEN(XLEN)) uut (
      .src_a    (src_a),
      .src_b    (src_b),
      .imm_val  (imm_val),
      .pc       (pc),
      .sel_imm  (sel_imm),
      .op       (op),
      .result   (result),
      .br_taken (br_taken)
   );

   function automatic int req_of(input logic [4:0] c);
      if (c <= 5'd1) return 2;
      if (c == 5'd2 || c == 5'd6 || c == 5'd7) return 4;
      if (c == 5'd3 || c == 5'd4) return 5;
      if (c == 5'd5 || c == 5'd8 || c == 5'd9) return 6;
      if (c == 5'd10) return 7;
      if (c <= 5'd13) return 8;
      if (c <= 5'd15) return 9;
      if (c == 5'd16) return 10;
      if (c <= 5'd22) return 11;
      return 12;
   endfunction

   // Behavioural reference built from the requirements.
   task automatic ref_model(input logic [4:0] c, input logic [63:0] a, b, im, p,
                            input logic s, output logic [63:0] r, output logic t);
      logic [63:0] ob;
      logic signed [63:0] sa;
      logic signed [31:0] sw;
      logic [31:0] w;
      ob = s ? im : b;
      sa = a;
      sw = a[31:0];
      r = '0;
      t = 1'b0;
      w = '0;
      case (c)
         5'd0:  r = a + ob;
         5'd1:  r = a - ob;
         5'd2:  r = a << ob[5:0];
         5'd3:  r = {63'd0, $signed(a) < $signed(ob)};
         5'd4:  r = {63'd0, a < ob};
         5'd5:  r = a ^ ob;
         5'd6:  r = a >> ob[5:0];
         5'd7:  r = sa >>> ob[5:0];
         5'd8:  r = a | ob;
         5'd9:  r = a & ob;
         5'd10: begin w = a[31:0] + ob[31:0];  r = {{32{w[31]}}, w}; end
         5'd11: begin w = a[31:0] << ob[4:0];  r = {{32{w[31]}}, w}; end
         5'd12: begin w = a[31:0] >> ob[4:0];  r = {{32{w[31]}}, w}; end
         5'd13: begin w = sw >>> ob[4:0];      r = {{32{w[31]}}, w}; end
         5'd14: r = im;
         5'd15: r = p + im;
         5'd16: r = p + 64'd4;
         5'd17: t = (a == b);
         5'd18: t = (a != b);
         5'd19: t = $signed(a) < $signed(b);
         5'd20: t = $signed(a) >= $signed(b);
         5'd21: t = a < b;
         5'd22: t = a >= b;
         default: ;
      endcase
   endtask

   task automatic check(input int req, input logic [63:0] er, input logic et);
      n_checks++;
      if (result !== er || br_taken !== et) begin
         n_fail++;
         $display("FAIL R%0d op=%0d: result=%h taken=%b expected result=%h taken=%b",
                  req, op, result, br_taken, er, et);
      end
   endtask

   task automatic apply(input logic [4:0] c, input logic [63:0] a, b, im, p, input logic s);
      @(posedge clk);
      op = c; src_a = a; src_b = b; imm_val = im; pc = p; sel_imm = s;
      @(negedge clk);
   endtask

   function automatic logic [63:0] pick_word();
      case ($urandom_range(0, 5))
         0: return 64'd0;
         1: return ONES;
         2: return MSB;
         3: return 64'h7FFF_FFFF_FFFF_FFFF;
         default: return {$urandom(), $urandom()};
      endcase
   endfunction

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      // R3: idle all-zero inputs give zero outputs
      @(negedge clk);
      check(3, 64'd0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         apply(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].imm, TBL[i].pcv, TBL[i].sel);
         check(int'(TBL[i].req), TBL[i].exp, TBL[i].tk);
      end

      // R3: outputs follow a new operand without waiting for another edge
      apply(5'd0, 64'd40, 64'd2, 64'd0, 64'd0, 1'b0);
      src_b = 64'd10;
      #1;
      check(3, 64'd50, 1'b0);

      for (int k = 0; k < NRAND; k++) begin
         logic [4:0]  c;
         logic [63:0] a, b, im, p, er;
         logic        s, et;
         c  = 5'($urandom_range(0, 31));
         a  = pick_word();
         b  = ($urandom_range(0, 7) == 0) ? a : pick_word();
         im = pick_word();
         p  = {$urandom(), $urandom()};
         s  = 1'($urandom_range(0, 1));
         ref_model(c, a, b, im, p, s, er, et);
         apply(c, a, b, im, p, s);
         check(req_of(c), er, et);
      end

      finished = 1'b1;
      report();
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         report();
      end
   end

   logic unused_rst;
   assign unused_rst = rst_n;

endmodule